// File: doc/BRIEF.md
# Endian-Consistent Register Lane Steering

This block sits between the register side of a processor data path and a 64-bit memory data bus. A single access may move one register (byte, word or long) or several registers at once (two words, two longs or four words). The memory only sees a 32-bit or 64-bit access and cannot tell a group of registers from one wide value. When the memory runs little-endian, it places the least significant bus byte at the lowest address. Without correction, each register of a group would then land at a different address than it does in big-endian mode.

The block fixes this by placing register slots on the bus in the opposite order when the mode is little-endian. The bytes inside each register keep their order. It is not a plain byte swap. The store side turns up to four register operands into one bus value. The load side applies the inverse mapping to the data read from memory. Both results pass through one register stage, and a valid bit travels with them. Transfer codes that are not defined produce zero data and a one-cycle error pulse.

Top module: `regLaneSteer`

## Requirements
- R1: During synchronous reset and in the first cycle after it, `outValid`, `typeErr`, `storeBus` and `loadRegs` are all zero.
- R2: `outValid` equals `inValid` delayed by exactly one clock. `storeBus`, `loadRegs` and `typeErr` update only on a clock where `inValid` is high. On other clocks the data outputs hold their values, and `typeErr` is low in the following cycle.
- R3: Single-register codes work the same in both modes. For code 0 (byte), `storeBus[7:0]` is register 0 bits [7:0]. For code 1 (word), `storeBus[15:0]` is register 0 bits [15:0]. For code 2 (long), `storeBus[31:0]` is register 0. All other bus bits are zero, and operand bits above the transfer width have no effect.
- R4: Code 3 (two words), big-endian (`littleEndian`=0): `storeBus[31:16]` is register 0 bits [15:0], `storeBus[15:0]` is register 1 bits [15:0], and bits [63:32] are zero. For example, 0x0102 and 0x0304 give 0x01020304.
- R5: Code 3, little-endian: register 1 goes in `storeBus[31:16]` and register 0 in `storeBus[15:0]`. For example, 0x0102 and 0x0304 give 0x03040102.
- R6: Code 4 (two longs): big-endian puts register 0 in `storeBus[63:32]` and register 1 in `storeBus[31:0]`. Little-endian puts register 0 in `storeBus[31:0]` and register 1 in `storeBus[63:32]`.
- R7: Code 5 (four words): big-endian puts register 0 bits [15:0] in `storeBus[63:48]`, down to register 3 in `storeBus[15:0]`. Little-endian puts register 0 in `storeBus[15:0]`, up to register 3 in `storeBus[63:48]`.
- R8: `loadRegs` applies the inverse of R3 to R7 to `memRdData`. Register i occupies `loadRegs[32*i+31:32*i]`. Each value is zero-extended to 32 bits, and registers not used by the code read zero.
- R9: If `memRdData` equals the store bus produced for some operands, code and mode, then `loadRegs` returns those operands truncated to the transfer width.
- R10: Codes 6 and 7 are undefined. When sent with `inValid` high, they produce zero `storeBus` and `loadRegs` and raise `typeErr` for exactly one cycle, together with `outValid`. `typeErr` never rises for any other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request valid |
| littleEndian | input | 1 | 1 = little-endian memory, 0 = big-endian |
| xferType | input | 3 | Transfer code (0 byte, 1 word, 2 long, 3 two words, 4 two longs, 5 four words) |
| storeRegs | input | 128 | Register operands; register i at bits [32*i+31:32*i] |
| memRdData | input | 64 | Data read from memory for the load path |
| outValid | output | 1 | Registered result valid |
| storeBus | output | 64 | Steered store data for the memory bus |
| loadRegs | output | 128 | Steered load results, register i at bits [32*i+31:32*i] |
| typeErr | output | 1 | One-cycle flag for an undefined transfer code |

## Verification
The bench uses the 0x0102/0x0304 pair in both modes. A design that byte-swapped instead of swapping slots would give 0x04030201 rather than 0x03040102, and one that never reversed would leave register 0 at the wrong address. Four-word and two-long transfers are tested in both modes to catch a swap that uses the wrong slot count, such as reversing in pairs. Byte and word transfers are sent with junk in the upper operand bits to catch leakage into the upper bus bits. Store-then-load round trips, undefined codes, and idle cycles with changing inputs expose an incorrect inverse mapping, a stuck or missing error pulse, or outputs that change without a valid request.

// File: rtl/laneSteerPkg.sv
package laneSteerPkg;

  // Width of the slot counter carried in the strobe struct (0..4 slots).
  localparam int SLOT_CNT_W = 3;

  typedef enum logic [2:0] {
    XT_BYTE      = 3'd0,
    XT_WORD      = 3'd1,
    XT_LONG      = 3'd2,
    XT_TWO_WORD  = 3'd3,
    XT_TWO_LONG  = 3'd4,
    XT_FOUR_WORD = 3'd5
  } xferKind_e;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_WORD = 2'd1,
    W_LONG = 2'd2
  } slotWidth_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                  capture;    // load the output registers this clock
    logic                  illegal;    // undefined transfer code
    slotWidth_e            width;      // size of one register slot on the bus
    logic [SLOT_CNT_W-1:0] slotCount;  // number of register slots in the transfer
    logic                  reverse;    // slot order reversed (big-endian)
  } steerCtl_t;

endpackage

// File: rtl/laneSteerCtrl.sv
module laneSteerCtrl
  import laneSteerPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       littleEndian,
  input  logic [2:0] xferType,
  output steerCtl_t  ctl,
  output logic       outValid,
  output logic       typeErr
);

  // Decode the transfer code into slot width, slot count and order.
  always_comb begin
    ctl.capture   = inValid;
    ctl.illegal   = 1'b0;
    ctl.width     = W_WORD;
    ctl.slotCount = SLOT_CNT_W'(1);
    ctl.reverse   = ~littleEndian;
    case (xferKind_e'(xferType))
      XT_BYTE:      ctl.width = W_BYTE;
      XT_WORD:      ctl.width = W_WORD;
      XT_LONG:      ctl.width = W_LONG;
      XT_TWO_WORD:  begin ctl.width = W_WORD; ctl.slotCount = SLOT_CNT_W'(2); end
      XT_TWO_LONG:  begin ctl.width = W_LONG; ctl.slotCount = SLOT_CNT_W'(2); end
      XT_FOUR_WORD: begin ctl.width = W_WORD; ctl.slotCount = SLOT_CNT_W'(4); end
      default: begin
        ctl.illegal   = 1'b1;
        ctl.slotCount = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      typeErr  <= 1'b0;
    end else begin
      outValid <= inValid;
      typeErr  <= inValid & ctl.illegal;
    end
  end

  // R2: valid is delayed by exactly one clock
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid && !typeErr);

  // R10: error pulse only for undefined codes, aligned with valid
  p_err_raise_r10: assert property (@(posedge clk) disable iff (rst)
    (inValid && xferType > 3'd5) |=> typeErr);
  p_err_cause_r10: assert property (@(posedge clk) disable iff (rst)
    typeErr |-> outValid && $past(xferType) > 3'd5);
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (inValid && xferType <= 3'd5) |=> !typeErr);

endmodule

// File: rtl/laneSteerPath.sv
module laneSteerPath
  import laneSteerPkg::*;
#(
  parameter int BUS_W    = 64,
  parameter int REG_W    = 32,
  parameter int NUM_REGS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  steerCtl_t                 ctl,
  input  logic [NUM_REGS*REG_W-1:0] storeRegs,
  input  logic [BUS_W-1:0]          memRdData,
  output logic [BUS_W-1:0]          storeBus,
  output logic [NUM_REGS*REG_W-1:0] loadRegs
);

  localparam int BYTE_W      = 8;
  localparam int WORD_W      = 16;
  localparam int LONG_W      = 32;
  localparam int WORD_LANES  = BUS_W / WORD_W;
  localparam int LONG_LANES  = BUS_W / LONG_W;
  localparam int REG_IDX_W   = $clog2(NUM_REGS);
  localparam int WLANE_IDX_W = $clog2(WORD_LANES);
  localparam int LLANE_IDX_W = (LONG_LANES > 1) ? $clog2(LONG_LANES) : 1;

  logic [NUM_REGS-1:0][REG_W-1:0]     regArr;
  logic [WORD_LANES-1:0][WORD_W-1:0]  busWords;
  logic [LONG_LANES-1:0][LONG_W-1:0]  busLongs;
  logic [WORD_LANES-1:0][WORD_W-1:0]  wordLane;
  logic [LONG_LANES-1:0][LONG_W-1:0]  longLane;
  logic [BUS_W-1:0]                   nextBus;
  logic [NUM_REGS-1:0][REG_W-1:0]     nextLoad;

  assign regArr   = storeRegs;
  assign busWords = memRdData;
  assign busLongs = memRdData;

  // Store side: pick which register feeds each bus slot.
  always_comb begin
    for (int k = 0; k < WORD_LANES; k++) begin
      logic [SLOT_CNT_W-1:0] pick;
      pick = ctl.reverse ? ctl.slotCount - SLOT_CNT_W'(k + 1) : SLOT_CNT_W'(k);
      wordLane[k] = '0;
      if (SLOT_CNT_W'(k) < ctl.slotCount)
        wordLane[k] = regArr[REG_IDX_W'(pick)][WORD_W-1:0];
    end
  end

  always_comb begin
    for (int k = 0; k < LONG_LANES; k++) begin
      logic [SLOT_CNT_W-1:0] pick;
      pick = ctl.reverse ? ctl.slotCount - SLOT_CNT_W'(k + 1) : SLOT_CNT_W'(k);
      longLane[k] = '0;
      if (SLOT_CNT_W'(k) < ctl.slotCount)
        longLane[k] = regArr[REG_IDX_W'(pick)][LONG_W-1:0];
    end
  end

  always_comb begin
    nextBus = '0;
    if (!ctl.illegal) begin
      case (ctl.width)
        W_BYTE:  nextBus = BUS_W'(regArr[0][BYTE_W-1:0]);
        W_WORD:  nextBus = wordLane;
        W_LONG:  nextBus = longLane;
        default: nextBus = '0;
      endcase
    end
  end

  // Load side: inverse mapping, one register at a time.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_load
    logic [SLOT_CNT_W-1:0] pick;
    logic                  hit;
    logic [REG_W-1:0]      byteVal;

    assign pick = ctl.reverse ? ctl.slotCount - SLOT_CNT_W'(i + 1) : SLOT_CNT_W'(i);
    assign hit  = SLOT_CNT_W'(i) < ctl.slotCount;

    if (i == 0) begin : g_byte
      assign byteVal = REG_W'(memRdData[BYTE_W-1:0]);
    end else begin : g_nobyte
      assign byteVal = '0;
    end

    always_comb begin
      nextLoad[i] = '0;
      if (hit && !ctl.illegal) begin
        case (ctl.width)
          W_BYTE:  nextLoad[i] = byteVal;
          W_WORD:  nextLoad[i] = REG_W'(busWords[WLANE_IDX_W'(pick)]);
          W_LONG:  nextLoad[i] = REG_W'(busLongs[LLANE_IDX_W'(pick)]);
          default: nextLoad[i] = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      storeBus <= '0;
      loadRegs <= '0;
    end else if (ctl.capture) begin
      storeBus <= nextBus;
      loadRegs <= nextLoad;
    end
  end

  // R2: data holds when no request arrives
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ctl.capture |=> $stable(storeBus) && $stable(loadRegs));

  // R10: undefined codes give zero data
  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl.capture && ctl.illegal) |=> storeBus == '0 && loadRegs == '0);

  // R3: a single word never spills above its slot
  p_single_word_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl.capture && !ctl.illegal && ctl.width == W_WORD && ctl.slotCount == SLOT_CNT_W'(1))
      |=> storeBus[BUS_W-1:WORD_W] == '0);

  // R8: registers beyond the slot count read zero (register 3 unused unless four words)
  p_unused_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.capture && ctl.slotCount < SLOT_CNT_W'(NUM_REGS)) |=> loadRegs[NUM_REGS*REG_W-1 -: REG_W] == '0);

endmodule

// File: rtl/regLaneSteer.sv
module regLaneSteer
  import laneSteerPkg::*;
#(
  parameter int BUS_W    = 64,
  parameter int REG_W    = 32,
  parameter int NUM_REGS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  input  logic                      littleEndian,
  input  logic [2:0]                xferType,
  input  logic [NUM_REGS*REG_W-1:0] storeRegs,
  input  logic [BUS_W-1:0]          memRdData,
  output logic                      outValid,
  output logic [BUS_W-1:0]          storeBus,
  output logic [NUM_REGS*REG_W-1:0] loadRegs,
  output logic                      typeErr
);

  steerCtl_t ctl;

  laneSteerCtrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .inValid      (inValid),
    .littleEndian (littleEndian),
    .xferType     (xferType),
    .ctl          (ctl),
    .outValid     (outValid),
    .typeErr      (typeErr)
  );

  laneSteerPath #(
    .BUS_W    (BUS_W),
    .REG_W    (REG_W),
    .NUM_REGS (NUM_REGS)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .storeRegs (storeRegs),
    .memRdData (memRdData),
    .storeBus  (storeBus),
    .loadRegs  (loadRegs)
  );

  // R1: everything idle in the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> !outValid && !typeErr && storeBus == '0 && loadRegs == '0);

endmodule

// File: tb/tb_regLaneSteer.sv
`timescale 1ns/1ps
module tb_regLaneSteer;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic         littleEndian;
  logic [2:0]   xferType;
  logic [127:0] storeRegs;
  logic [63:0]  memRdData;
  logic         outValid;
  logic [63:0]  storeBus;
  logic [127:0] loadRegs;
  logic         typeErr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  regLaneSteer dut (
    .clk(clk), .rst(rst), .inValid(inValid), .littleEndian(littleEndian),
    .xferType(xferType), .storeRegs(storeRegs), .memRdData(memRdData),
    .outValid(outValid), .storeBus(storeBus), .loadRegs(loadRegs), .typeErr(typeErr)
  );

  function automatic logic [63:0] expStore(logic [2:0] t, logic le,
                                            logic [31:0] a, b, c, d);
    case (t)
      3'd0: return {56'h0, a[7:0]};
      3'd1: return {48'h0, a[15:0]};
      3'd2: return {32'h0, a};
      3'd3: return le ? {32'h0, b[15:0], a[15:0]} : {32'h0, a[15:0], b[15:0]};
      3'd4: return le ? {b, a} : {a, b};
      3'd5: return le ? {d[15:0], c[15:0], b[15:0], a[15:0]}
                      : {a[15:0], b[15:0], c[15:0], d[15:0]};
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [127:0] expLoad(logic [2:0] t, logic le, logic [63:0] m);
    case (t)
      3'd0: return {120'h0, m[7:0]};
      3'd1: return {112'h0, m[15:0]};
      3'd2: return {96'h0, m[31:0]};
      3'd3: return le ? {64'h0, 16'h0, m[31:16], 16'h0, m[15:0]}
                      : {64'h0, 16'h0, m[15:0], 16'h0, m[31:16]};
      3'd4: return le ? {64'h0, m[63:32], m[31:0]} : {64'h0, m[31:0], m[63:32]};
      3'd5: return le ? {16'h0, m[63:48], 16'h0, m[47:32], 16'h0, m[31:16], 16'h0, m[15:0]}
                      : {16'h0, m[15:0], 16'h0, m[31:16], 16'h0, m[47:32], 16'h0, m[63:48]};
      default: return 128'h0;
    endcase
  endfunction

  function automatic logic [127:0] expTrunc(logic [2:0] t, logic [31:0] a, b, c, d);
    case (t)
      3'd0: return {120'h0, a[7:0]};
      3'd1: return {112'h0, a[15:0]};
      3'd2: return {96'h0, a};
      3'd3: return {64'h0, 16'h0, b[15:0], 16'h0, a[15:0]};
      3'd4: return {64'h0, b, a};
      3'd5: return {16'h0, d[15:0], 16'h0, c[15:0], 16'h0, b[15:0], 16'h0, a[15:0]};
      default: return 128'h0;
    endcase
  endfunction

  task automatic checkEq(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge, then check at the next falling edge.
  task automatic xfer(logic [2:0] t, logic le, logic [31:0] a, b, c, d,
                      logic [63:0] m, string tag);
    inValid = 1'b1; xferType = t; littleEndian = le;
    storeRegs = {d, c, b, a}; memRdData = m;
    @(negedge clk);
    checkEq("R2", "outValid", 128'(outValid), 128'd1);
    checkEq(tag, "storeBus", 128'(storeBus), 128'(expStore(t, le, a, b, c, d)));
    checkEq(tag, "loadRegs", loadRegs, expLoad(t, le, m));
    checkEq("R10", "typeErr", 128'(typeErr), 128'(t > 3'd5));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual still running expected finished");
    finishRun();
  end

  initial begin
    logic [63:0]  heldBus;
    logic [127:0] heldLoad;
    void'($urandom(32'h1F2E3D4C));
    rst = 1'b1; inValid = 1'b0; littleEndian = 1'b0; xferType = 3'd0;
    storeRegs = '1; memRdData = '1;
    repeat (3) @(negedge clk);
    // R1: state during reset
    checkEq("R1", "outValid", 128'(outValid), 128'd0);
    checkEq("R1", "storeBus", 128'(storeBus), 128'd0);
    checkEq("R1", "loadRegs", loadRegs, 128'd0);
    checkEq("R1", "typeErr", 128'(typeErr), 128'd0);
    rst = 1'b0;

    // R4 / R5: the classic two-word pair
    xfer(3'd3, 1'b0, 32'h0102, 32'h0304, 0, 0, 64'h0, "R4");
    checkEq("R4", "example", 128'(storeBus), 128'h01020304);
    xfer(3'd3, 1'b1, 32'h0102, 32'h0304, 0, 0, 64'h0, "R5");
    checkEq("R5", "example", 128'(storeBus), 128'h03040102);

    // R3: single registers with junk above the width, both modes
    xfer(3'd0, 1'b0, 32'hDEADBEA5, 32'hFFFF_FFFF, 32'h1, 32'h2, 64'hFFEE_DDCC_BBAA_9988, "R3");
    xfer(3'd0, 1'b1, 32'hDEADBEA5, 32'hFFFF_FFFF, 32'h1, 32'h2, 64'hFFEE_DDCC_BBAA_9988, "R3");
    xfer(3'd1, 1'b1, 32'hCAFE1234, 32'h5555_5555, 0, 0, 64'h1111_2222_3333_4444, "R3");
    xfer(3'd2, 1'b0, 32'h89AB_CDEF, 32'h7777_7777, 0, 0, 64'h0123_4567_89AB_CDEF, "R3");

    // R6 / R7: wide transfers in both modes
    xfer(3'd4, 1'b0, 32'h11223344, 32'h55667788, 0, 0, 64'hA1A2_A3A4_B1B2_B3B4, "R6");
    xfer(3'd4, 1'b1, 32'h11223344, 32'h55667788, 0, 0, 64'hA1A2_A3A4_B1B2_B3B4, "R6");
    xfer(3'd5, 1'b0, 32'h0000AAAA, 32'h0000BBBB, 32'h0000CCCC, 32'h0000DDDD,
         64'h1111_2222_3333_4444, "R7");
    checkEq("R8", "four-word BE reg0", 128'(loadRegs[31:0]), 128'h1111);
    xfer(3'd5, 1'b1, 32'h0000AAAA, 32'h0000BBBB, 32'h0000CCCC, 32'h0000DDDD,
         64'h1111_2222_3333_4444, "R7");
    checkEq("R8", "four-word LE reg0", 128'(loadRegs[31:0]), 128'h4444);

    // R10: undefined codes, then a legal one clears the flag
    xfer(3'd6, 1'b0, 32'h12345678, 32'h1, 32'h2, 32'h3, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
    xfer(3'd7, 1'b1, 32'h12345678, 32'h1, 32'h2, 32'h3, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
    xfer(3'd2, 1'b1, 32'h0BAD_F00D, 0, 0, 0, 64'h5A5A, "R10");

    // R2: idle cycles with changing inputs hold the data outputs
    heldBus = storeBus; heldLoad = loadRegs;
    inValid = 1'b0; xferType = 3'd5; littleEndian = 1'b0;
    storeRegs = {4{32'h3C3C_C3C3}}; memRdData = 64'h9999_8888_7777_6666;
    @(negedge clk);
    checkEq("R2", "idle outValid", 128'(outValid), 128'd0);
    checkEq("R2", "idle storeBus", 128'(storeBus), 128'(heldBus));
    checkEq("R2", "idle loadRegs", loadRegs, heldLoad);
    xferType = 3'd7;
    @(negedge clk);
    checkEq("R10", "idle undefined code", 128'(typeErr), 128'd0);
    checkEq("R2", "idle storeBus 2", 128'(storeBus), 128'(heldBus));

    // Random mix with round trips (R8, R9)
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  t;
      logic        le;
      logic [31:0] a, b, c, d;
      logic [63:0] m;
      bit          trip;
      t = 3'($urandom_range(0, 7));
      le = 1'($urandom);
      a = $urandom; b = $urandom; c = $urandom; d = $urandom;
      trip = ($urandom_range(0, 1) == 1) && (t <= 3'd5);
      m = trip ? expStore(t, le, a, b, c, d) : {$urandom, $urandom};
      xfer(t, le, a, b, c, d, m, "R8");
      if (trip) checkEq("R9", "round trip", loadRegs, expTrunc(t, a, b, c, d));
      if (($urandom % 4) == 0) begin
        inValid = 1'b0;
        @(negedge clk);
        checkEq("R2", "gap outValid", 128'(outValid), 128'd0);
        checkEq("R2", "gap typeErr", 128'(typeErr), 128'd0);
      end
    end

    // R1: reset mid-stream clears everything
    xfer(3'd4, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    checkEq("R1", "post-reset storeBus", 128'(storeBus), 128'd0);
    checkEq("R1", "post-reset loadRegs", loadRegs, 128'd0);
    checkEq("R1", "post-reset outValid", 128'(outValid), 128'd0);
    @(negedge clk);
    finishRun();
  end

endmodule